// File: doc/BRIEF.md
# CHS to LBA Sector Translator

The block turns a task-file sector address into a linear sector address. It checks that address against the capacity of the installed flash. The host-side register logic loads the four address bytes: sector, cylinder low, cylinder high and drive/head. The block holds them and presents the linear address together with a range-error flag. A range error should raise the ID-not-found condition in the error register. The block also presents the geometry that the current configuration implies: the head count and the sectors per track.

The number of flash chips and their density set the geometry. The cylinder limit is held in a writable register, which defaults to 1000 after reset. During multi-sector commands the sequencer pulses an advance input after each sector. The held address then moves to the next sector in the current addressing scheme. The updated bytes are driven back out, so the task file can show the last address that was processed.

Top module: `chs_lba_xlate`

## Requirements
- R1: When dev_head bit 6 is 1 (linear mode), the address is {dev_head[3:0], cyl_hi, cyl_lo, sec_num}, 28 bits, with sec_num in the low byte.
- R2: When dev_head bit 6 is 0, the address is (cylinder × heads + head) × sectors + sector − 1. Here cylinder is {cyl_hi, cyl_lo} and head is dev_head[3:0].
- R3: Geometry uses chips encoding 0 = 1 chip, 1 = 2 chips, 2 or 3 = 4 chips, and density encoding 0/1/2/3 = 64/128/256/512 Mbit. For 1, 2 and 4 chips, heads/sectors are 1/16, 1/32, 2/32 at 64 Mbit; 1/32, 1/64, 2/64 at 128 Mbit; 2/32, 2/64, 4/64 at 256 Mbit; and 4/32, 4/64, 8/64 at 512 Mbit.
- R4: Capacity is the cylinder limit × heads × sectors. It is registered and follows a configuration change one clock later. range_err_o is 1 whenever the address is greater than or equal to the capacity.
- R5: The cylinder limit resets to 1000. A clock with cyl_max_wr_i high loads cyl_max_i, which affects the capacity from the following clock.
- R6: In per-track mode, range_err_o is also 1 in three cases: the sector is 0, the sector exceeds the sectors per track, or the head is not below the head count.
- R7: When adv_i is high in per-track mode, the sector increments. If the sector is already at or beyond the last one, it becomes 1 and the head increments. If the head is at or beyond the last one, it becomes 0 and the cylinder increments, wrapping at 16 bits.
- R8: When adv_i is high in linear mode, the 28-bit address increments, with carry into dev_head[3:0]. dev_head[7:4] is left unchanged.
- R9: When load_i is high, the four input bytes are captured and appear on the outputs after that clock edge. load_i takes priority over adv_i.
- R10: After reset, the outputs show sector 1, cylinder 0 and dev_head 0xA0 (per-track mode, drive 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chips_i | input | 2 | Installed chip count code |
| density_i | input | 2 | Per-chip density code |
| cyl_max_wr_i | input | 1 | Load the cylinder limit |
| cyl_max_i | input | 16 | New cylinder limit |
| load_i | input | 1 | Capture the task-file address bytes |
| adv_i | input | 1 | Step to the next sector |
| sec_num_i | input | 8 | Sector byte in |
| cyl_lo_i | input | 8 | Cylinder low byte in |
| cyl_hi_i | input | 8 | Cylinder high byte in |
| dev_head_i | input | 8 | Drive/head byte in |
| sec_num_o | output | 8 | Held sector byte |
| cyl_lo_o | output | 8 | Held cylinder low byte |
| cyl_hi_o | output | 8 | Held cylinder high byte |
| dev_head_o | output | 8 | Held drive/head byte |
| lba_o | output | 28 | Linear sector address |
| range_err_o | output | 1 | Address invalid or beyond capacity |
| heads_o | output | 4 | Heads per cylinder |
| spt_o | output | 8 | Sectors per track |

## Verification
The bench uses the default cylinder limit of 1000 and the fixed 28-bit address width. The full 1000-cylinder, 8-head, 64-sector configuration therefore places the capacity edge at 512000 (0x7D000), where it can be stepped across with one advance. A linear address of 0x0FFFFFF carries into the drive/head nibble. The cylinder register is also rewritten to small values and to zero, so the capacity boundary moves within reach of short runs, and a zero capacity makes every address out of range.

// File: rtl/chs_xlate_pkg.sv
package chs_xlate_pkg;
  localparam int SEC_W = 8;
  localparam int CYL_W = 16;
  localparam int HD_W  = 4;
  localparam int LBA_W = HD_W + CYL_W + SEC_W;

  typedef struct packed {
    logic [1:0] hsh;  // log2 heads
    logic [2:0] ssh;  // log2 sectors per track
  } geom_t;
endpackage

// File: rtl/chs_geom.sv
module chs_geom
  import chs_xlate_pkg::*;
(
  input  logic [1:0] chips_i,
  input  logic [1:0] density_i,
  output geom_t      geom_o,
  output logic [3:0] heads_o,
  output logic [7:0] spt_o
);
  logic [1:0] cidx;
  logic [3:0] tot_sh, s_sh;

  always_comb begin
    cidx    = (chips_i == 2'd3) ? 2'd2 : chips_i;
    // sectors per cylinder doubles with each density and chip step
    tot_sh  = 4'd4 + {2'b00, density_i} + {2'b00, cidx};
    s_sh    = ((density_i == 2'd0) ? 4'd4 : 4'd5) + {3'b000, (cidx != 2'd0)};
    geom_o.ssh = s_sh[2:0];
    geom_o.hsh = 2'(tot_sh - s_sh);
    heads_o = 4'd1 << geom_o.hsh;
    spt_o   = 8'd1 << geom_o.ssh;
  end
endmodule

// File: rtl/chs_cap.sv
module chs_cap
  import chs_xlate_pkg::*;
#(
  parameter int CYL_DEF = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyl_wr_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  geom_t            geom_i,
  output logic [LBA_W-1:0] cap_o
);
  logic [CYL_W-1:0] cyl_max_q;
  logic [LBA_W-1:0] cap_q;
  logic [3:0]       sh;

  assign sh    = {2'b00, geom_i.hsh} + {1'b0, geom_i.ssh};
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_max_q <= CYL_W'(CYL_DEF);
      cap_q     <= '0;
    end else begin
      if (cyl_wr_i) cyl_max_q <= cyl_i;
      cap_q <= LBA_W'(cyl_max_q) << sh;
    end
  end
endmodule

// File: rtl/chs_addr.sv
module chs_addr
  import chs_xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [SEC_W-1:0] sn_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  logic [7:0]       dh_i,
  input  logic [3:0]       heads_i,
  input  logic [7:0]       spt_i,
  output logic [SEC_W-1:0] sn_o,
  output logic [CYL_W-1:0] cyl_o,
  output logic [7:0]       dh_o
);
  logic [SEC_W-1:0] sn_q, sn_n;
  logic [CYL_W-1:0] cyl_q, cyl_n;
  logic [7:0]       dh_q, dh_n;

  always_comb begin
    sn_n  = sn_q;
    cyl_n = cyl_q;
    dh_n  = dh_q;
    if (dh_q[6]) begin
      {dh_n[HD_W-1:0], cyl_n, sn_n} = {dh_q[HD_W-1:0], cyl_q, sn_q} + LBA_W'(1);
    end else if (sn_q < spt_i) begin
      sn_n = sn_q + 8'd1;
    end else begin
      sn_n = 8'd1;
      if (dh_q[3:0] < heads_i - 4'd1) begin
        dh_n[3:0] = dh_q[3:0] + 4'd1;
      end else begin
        dh_n[3:0] = 4'd0;
        cyl_n     = cyl_q + CYL_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sn_q  <= 8'd1;
      cyl_q <= '0;
      dh_q  <= 8'hA0;
    end else if (load_i) begin
      sn_q  <= sn_i;
      cyl_q <= cyl_i;
      dh_q  <= dh_i;
    end else if (adv_i) begin
      sn_q  <= sn_n;
      cyl_q <= cyl_n;
      dh_q  <= dh_n;
    end
  end

  assign sn_o  = sn_q;
  assign cyl_o = cyl_q;
  assign dh_o  = dh_q;
endmodule

// File: rtl/chs_map.sv
module chs_map
  import chs_xlate_pkg::*;
(
  input  logic [SEC_W-1:0] sn_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  logic [7:0]       dh_i,
  input  geom_t            geom_i,
  input  logic [3:0]       heads_i,
  input  logic [7:0]       spt_i,
  input  logic [LBA_W-1:0] cap_i,
  output logic [LBA_W-1:0] lba_o,
  output logic             err_o
);
  logic [LBA_W-1:0] lba_lin, lba_trk;
  logic [3:0]       csh;
  logic             bad_fld;

  always_comb begin
    csh     = {2'b00, geom_i.hsh} + {1'b0, geom_i.ssh};
    lba_lin = {dh_i[HD_W-1:0], cyl_i, sn_i};
    lba_trk = (LBA_W'(cyl_i) << csh) + (LBA_W'(dh_i[3:0]) << geom_i.ssh)
            + LBA_W'(sn_i) - LBA_W'(1);
    bad_fld = (sn_i == '0) || (sn_i > spt_i) || (dh_i[3:0] >= heads_i);
    lba_o   = dh_i[6] ? lba_lin : lba_trk;
    err_o   = (lba_o >= cap_i) || (!dh_i[6] && bad_fld);
  end
endmodule

// File: rtl/chs_lba_xlate.sv
module chs_lba_xlate
  import chs_xlate_pkg::*;
#(
  parameter int CYL_DEF = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  chips_i,
  input  logic [1:0]  density_i,
  input  logic        cyl_max_wr_i,
  input  logic [15:0] cyl_max_i,
  input  logic        load_i,
  input  logic        adv_i,
  input  logic [7:0]  sec_num_i,
  input  logic [7:0]  cyl_lo_i,
  input  logic [7:0]  cyl_hi_i,
  input  logic [7:0]  dev_head_i,
  output logic [7:0]  sec_num_o,
  output logic [7:0]  cyl_lo_o,
  output logic [7:0]  cyl_hi_o,
  output logic [7:0]  dev_head_o,
  output logic [27:0] lba_o,
  output logic        range_err_o,
  output logic [3:0]  heads_o,
  output logic [7:0]  spt_o
);
  geom_t            geom;
  logic [LBA_W-1:0] cap;
  logic [CYL_W-1:0] cyl_q;
  logic [SEC_W-1:0] sn_q;
  logic [7:0]       dh_q;

  chs_geom u_geom (
    .chips_i  (chips_i),
    .density_i(density_i),
    .geom_o   (geom),
    .heads_o  (heads_o),
    .spt_o    (spt_o)
  );

  chs_cap #(.CYL_DEF(CYL_DEF)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cyl_wr_i(cyl_max_wr_i),
    .cyl_i   (cyl_max_i),
    .geom_i  (geom),
    .cap_o   (cap)
  );

  chs_addr u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_i  (adv_i),
    .sn_i   (sec_num_i),
    .cyl_i  ({cyl_hi_i, cyl_lo_i}),
    .dh_i   (dev_head_i),
    .heads_i(heads_o),
    .spt_i  (spt_o),
    .sn_o   (sn_q),
    .cyl_o  (cyl_q),
    .dh_o   (dh_q)
  );

  chs_map u_map (
    .sn_i   (sn_q),
    .cyl_i  (cyl_q),
    .dh_i   (dh_q),
    .geom_i (geom),
    .heads_i(heads_o),
    .spt_i  (spt_o),
    .cap_i  (cap),
    .lba_o  (lba_o),
    .err_o  (range_err_o)
  );

  assign sec_num_o  = sn_q;
  assign cyl_lo_o   = cyl_q[7:0];
  assign cyl_hi_o   = cyl_q[15:8];
  assign dev_head_o = dh_q;
endmodule

// File: rtl/chs_lba_xlate_chk.sv
module chs_lba_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_i,
  input logic        adv_i,
  input logic [7:0]  sec_num_i,
  input logic [7:0]  dev_head_i,
  input logic [7:0]  sec_num_o,
  input logic [7:0]  cyl_lo_o,
  input logic [7:0]  cyl_hi_o,
  input logic [7:0]  dev_head_o,
  input logic [27:0] lba_o,
  input logic        range_err_o,
  input logic [3:0]  heads_o,
  input logic [7:0]  spt_o
);
  a_r3_geom_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(heads_o) && ($countones(spt_o) == 1) && (spt_o >= 8'd16) && (spt_o <= 8'd64));

  a_r1_lin_pack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_head_o[6] |-> lba_o == {dev_head_o[3:0], cyl_hi_o, cyl_lo_o, sec_num_o});

  a_r6_bad_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_head_o[6] && (sec_num_o == 8'd0 || sec_num_o > spt_o)) |-> range_err_o);

  a_r7_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !dev_head_o[6] && sec_num_o < spt_o)
    |=> (sec_num_o == $past(sec_num_o) + 8'd1) && $stable(cyl_lo_o) && $stable(dev_head_o));

  a_r7_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !dev_head_o[6] && sec_num_o >= spt_o) |=> sec_num_o == 8'd1);

  a_r8_lin_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && dev_head_o[6])
    |=> (lba_o == $past(lba_o) + 28'd1) && (dev_head_o[7:4] == $past(dev_head_o[7:4])));

  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_num_o == $past(sec_num_i)) && (dev_head_o == $past(dev_head_i)));
endmodule

bind chs_lba_xlate chs_lba_xlate_chk u_chk (.*);

// File: tb/sim_chs_lba_xlate.sv
module sim_chs_lba_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chips = 2'd0, dens = 2'd0;
  logic        cyl_wr = 1'b0;
  logic [15:0] cyl_val = 16'd0;
  logic        load = 1'b0, adv = 1'b0;
  logic [7:0]  sn_i = 8'd0, cl_i = 8'd0, ch_i = 8'd0, dh_i = 8'd0;
  logic [7:0]  sn_o, cl_o, ch_o, dh_o, spt_o;
  logic [27:0] lba_o;
  logic        err_o;
  logic [3:0]  heads_o;

  always #5 clk = ~clk;

  chs_lba_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .chips_i(chips), .density_i(dens),
    .cyl_max_wr_i(cyl_wr), .cyl_max_i(cyl_val), .load_i(load), .adv_i(adv),
    .sec_num_i(sn_i), .cyl_lo_i(cl_i), .cyl_hi_i(ch_i), .dev_head_i(dh_i),
    .sec_num_o(sn_o), .cyl_lo_o(cl_o), .cyl_hi_o(ch_o), .dev_head_o(dh_o),
    .lba_o(lba_o), .range_err_o(err_o), .heads_o(heads_o), .spt_o(spt_o)
  );

  int    errs = 0, checks = 0;
  bit    done = 0;
  string req = "R10";

  // reference state
  longint m_sn, m_cyl, m_dh, m_cylmax, m_cap;

  task automatic geo(input int d, input int c, output int h, output int s);
    int cc;
    cc = (c == 3) ? 2 : c;
    case (d * 4 + cc)
      0: begin h = 1; s = 16; end
      1: begin h = 1; s = 32; end
      2: begin h = 2; s = 32; end
      4: begin h = 1; s = 32; end
      5: begin h = 1; s = 64; end
      6: begin h = 2; s = 64; end
      8: begin h = 2; s = 32; end
      9: begin h = 2; s = 64; end
      10: begin h = 4; s = 64; end
      12: begin h = 4; s = 32; end
      13: begin h = 4; s = 64; end
      default: begin h = 8; s = 64; end
    endcase
  endtask

  function automatic longint lin_of(longint sn, longint cyl, longint dh);
    return ((dh & 15) << 24) | (cyl << 8) | sn;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int h, s;
    longint v;
    if (!rst_n) begin
      m_sn = 1; m_cyl = 0; m_dh = 'hA0; m_cylmax = 1000; m_cap = 0;
    end else begin
      geo(int'(dens), int'(chips), h, s);
      m_cap = m_cylmax * h * s;
      if (cyl_wr) m_cylmax = cyl_val;
      if (load) begin
        m_sn = sn_i; m_cyl = {ch_i, cl_i}; m_dh = dh_i;
      end else if (adv) begin
        if (m_dh[6]) begin
          v = (lin_of(m_sn, m_cyl, m_dh) + 1) & 'hFFFFFFF;
          m_sn = v & 'hFF; m_cyl = (v >> 8) & 'hFFFF;
          m_dh = (m_dh & 'hF0) | ((v >> 24) & 15);
        end else if (m_sn < s) begin
          m_sn = m_sn + 1;
        end else begin
          m_sn = 1;
          if ((m_dh & 15) < h - 1) m_dh = m_dh + 1;
          else begin
            m_dh = m_dh & 'hF0;
            m_cyl = (m_cyl + 1) & 'hFFFF;
          end
        end
      end
    end
  end

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic compare();
    int h, s;
    longint e_lba;
    bit e_err;
    geo(int'(dens), int'(chips), h, s);
    if (m_dh[6]) begin
      e_lba = lin_of(m_sn, m_cyl, m_dh);
      e_err = (e_lba >= m_cap);
    end else begin
      e_lba = ((m_cyl * h + (m_dh & 15)) * s + m_sn - 1) & 'hFFFFFFF;
      e_err = (e_lba >= m_cap) || m_sn == 0 || m_sn > s || (m_dh & 15) >= h;
    end
    chk(req, "lba", 32'(lba_o), 32'(e_lba));
    chk(req, "range_err", 32'(err_o), 32'(e_err));
    chk(req, "sec_num", 32'(sn_o), 32'(m_sn));
    chk(req, "cylinder", {16'd0, ch_o, cl_o}, 32'(m_cyl));
    chk(req, "dev_head", 32'(dh_o), 32'(m_dh));
    chk("R3", "heads", 32'(heads_o), 32'(h));
    chk("R3", "spt", 32'(spt_o), 32'(s));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic ld(input logic [7:0] dh, input logic [15:0] cyl, input logic [7:0] sn);
    dh_i = dh; ch_i = cyl[15:8]; cl_i = cyl[7:0]; sn_i = sn;
    load = 1'b1; cyc(); load = 1'b0;
  endtask

  task automatic step();
    adv = 1'b1; cyc(); adv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    req = "R10";
    @(negedge clk);
    compare();
    chk("R10", "reset sec", 32'(sn_o), 32'd1);
    chk("R10", "reset dh", 32'(dh_o), 32'hA0);
    cyc();
    // R5 default 1000 cylinders: 1x64Mbit -> 16000 sectors
    req = "R5";
    ld(8'hE0, 16'h3E, 8'h7F);  // 15999
    chk("R5", "in range at 15999", 32'(err_o), 32'd0);
    ld(8'hE0, 16'h3E, 8'h80);  // 16000
    chk("R5", "out of range at 16000", 32'(err_o), 32'd1);
    // R3 geometry sweep
    req = "R3";
    for (int d = 0; d < 4; d++)
      for (int c = 0; c < 4; c++) begin
        dens = 2'(d); chips = 2'(c);
        cyc(); cyc();
      end
    // R2 / R4 / R7 at largest configuration (8 heads, 64 sectors)
    dens = 2'd3; chips = 2'd2; cyc();
    req = "R2";
    ld(8'hA7, 16'd999, 8'd64);
    chk("R2", "last sector lba", 32'(lba_o), 32'h7CFFF);
    chk("R4", "last sector in range", 32'(err_o), 32'd0);
    req = "R7";
    step();
    chk("R7", "cylinder carry", {16'd0, ch_o, cl_o}, 32'd1000);
    chk("R4", "capacity edge", 32'(err_o), 32'd1);
    ld(8'hA3, 16'd5, 8'd10);
    step(); step();
    chk("R7", "sector step", 32'(sn_o), 32'd12);
    ld(8'hA3, 16'd5, 8'd64);
    step();
    chk("R7", "head carry", 32'(dh_o), 32'hA4);
    // R8 linear stepping
    req = "R8";
    ld(8'hE0, 16'h7CF, 8'hFF);
    chk("R1", "linear pack", 32'(lba_o), 32'h7CFFF);
    step();
    chk("R8", "linear edge", 32'(lba_o), 32'h7D000);
    chk("R4", "linear edge err", 32'(err_o), 32'd1);
    ld(8'hF0, 16'hFFFF, 8'hFF);
    step();
    chk("R8", "nibble carry", 32'(dh_o), 32'hF1);
    // R6 invalid fields
    req = "R6";
    ld(8'hA0, 16'd0, 8'd0);
    chk("R6", "sector zero", 32'(err_o), 32'd1);
    ld(8'hA0, 16'd0, 8'd65);
    chk("R6", "sector above spt", 32'(err_o), 32'd1);
    ld(8'hA8, 16'd0, 8'd1);
    chk("R6", "head above count", 32'(err_o), 32'd1);
    // R5 / R4 cylinder limit rewrite
    req = "R4";
    cyl_val = 16'd10; cyl_wr = 1'b1; cyc(); cyl_wr = 1'b0; cyc();
    ld(8'hE0, 16'h13, 8'hFF);  // 5119
    chk("R5", "new limit in range", 32'(err_o), 32'd0);
    step();
    chk("R5", "new limit edge", 32'(err_o), 32'd1);
    cyl_val = 16'd0; cyl_wr = 1'b1; cyc(); cyl_wr = 1'b0; cyc();
    ld(8'hE0, 16'd0, 8'd0);
    chk("R4", "zero capacity", 32'(err_o), 32'd1);
    cyl_val = 16'd1000; cyl_wr = 1'b1; cyc(); cyl_wr = 1'b0; cyc();
    // R9 load priority
    req = "R9";
    dh_i = 8'hA1; ch_i = 8'd0; cl_i = 8'd7; sn_i = 8'd3;
    load = 1'b1; adv = 1'b1; cyc(); load = 1'b0; adv = 1'b0;
    chk("R9", "load wins", 32'(sn_o), 32'd3);
    // mixed random traffic
    req = "R2";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        dens = 2'($urandom); chips = 2'($urandom);
      end
      if ($urandom_range(0, 31) == 0) begin
        cyl_wr = 1'b1; cyl_val = 16'($urandom_range(0, 1200));
      end else cyl_wr = 1'b0;
      load = ($urandom_range(0, 5) == 0);
      adv  = ($urandom_range(0, 1) == 0);
      dh_i = {1'b1, 1'($urandom), 1'b1, 1'($urandom), 4'($urandom_range(0, 9))};
      ch_i = 8'($urandom_range(0, 4));
      cl_i = 8'($urandom);
      sn_i = 8'($urandom_range(0, 66));
      req  = dh_o[6] ? "R8" : "R7";
      cyc();
    end
    load = 1'b0; adv = 1'b0; cyl_wr = 1'b0;
    cyc();
    finish_run();
  end
endmodule